// File: doc/BRIEF.md
# Quadrature Position Counter with Index Clear

This block tracks shaft or slide position from an incremental encoder. It watches two phase signals that are a quarter period apart and counts every edge of either one, which gives four counts per encoder line. The order of the edges sets the count direction. The count is held in a free-running register of parameterised width, 16 bits by default. The register wraps past its top and bottom values and sends out a one-cycle interrupt pulse each time it does.

A third encoder signal, the once-per-revolution index mark, can return the count to zero. Software arms this by writing zero to the count and setting an index-enable bit. A polarity bit selects which index edge is active. The clear never happens at once. It takes effect at the count-source tick that follows the tick on which the edge was seen, and only if the index signal is still at its active level then. A wrap that falls on the same tick as a clear produces two interrupt pulses in a row.

All three encoder inputs pass through a two-stage synchronizer. Past the synchronizer they are looked at only on cycles where the count-source enable is high.

Top module: `quad_index_counter`

## Requirements
- R1: While reset is asserted and after it is released, `count` reads 0 and `wrap_irq` is low.
- R2: The phase pair {ph_a, ph_b} steps forward along 00, 10, 11, 01, 00. Each such step adds one to `count`. The new value appears on the third rising clock edge after the input changes, when `cnt_en` is high on every cycle.
- R3: A step in the reverse order (00, 01, 11, 10, 00) subtracts one from `count`.
- R4: When both phases change between two samples, `count` does not change. The new phase pair becomes the reference for the next step.
- R5: When `cnt_en` is low, phase and index changes have no effect. A phase change held across that time is counted at the first enabled cycle once `cnt_en` returns high.
- R6: The counter wraps from all-ones to 0 on an up step and from 0 to all-ones on a down step. Each wrap makes `wrap_irq` high for exactly the one cycle after the step.
- R7: When `wr_en` is high, `count` takes `wr_data` at the next clock edge. This has priority over any step or clear in that cycle.
- R8: The index clear is armed only when the most recent write was the value 0 and `idx_enable` is 1. A write of any non-zero value disarms it.
- R9: When `idx_rising` is 1, the rising edge of `idx_in` is active. When it is 0, the falling edge is active and the rising edge is ignored.
- R10: A qualified index edge seen on one enabled tick clears `count` to exactly 0 on the next enabled tick. Any phase step on that clearing tick is discarded.
- R11: An index pulse that has left its active level again by the tick after the edge was seen is rejected, and `count` keeps its value.
- R12: When a wrap and an index clear fall on the same tick, `count` becomes 0 and `wrap_irq` is high for two consecutive cycles.
- R13: When `idx_enable` is 0, index edges have no effect on `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count-source enable; inputs are sampled only when high |
| ph_a | input | 1 | Encoder phase A |
| ph_b | input | 1 | Encoder phase B |
| idx_in | input | 1 | Encoder index mark |
| wr_en | input | 1 | Load strobe for the count register |
| wr_data | input | WIDTH | Value to load |
| idx_enable | input | 1 | Lets index edges clear the count |
| idx_rising | input | 1 | Index polarity: 1 rising, 0 falling |
| count | output | WIDTH | Current position count |
| wrap_irq | output | 1 | Overflow/underflow interrupt pulse |

## Verification
A phase change on the pins shows up on `count` on the third rising edge when `cnt_en` is high every cycle: two synchronizer stages, then the counting tick. An index edge clears on the fourth edge, because it is recognised on the third and acted on at the next tick. The interrupt pulse is visible in the cycle that follows the wrapping tick. A coincident clear and wrap keep it high for one more cycle. The bench drives inputs on falling edges and waits exactly these numbers of rising edges before it samples. It checks the value both one edge before and on the edge where a change is due, so an extra or a missing register stage is reported.

// File: rtl/quad_index_pkg.sv
// Package: shared types for the quadrature position counter.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package quad_index_pkg;

    // Direction decided for one count-source tick
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;

    // Position of a phase pair on the forward cycle 00,10,11,01
    function automatic logic [1:0] phase_pos(input logic a, input logic b);
        case ({a, b})
            2'b00:   return 2'd0;
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/quad_sync.sv
// Module: multi-bit, multi-stage flip-flop synchronizer.
// Assumes each bit is an independent slow signal; no bus coherence is implied.
module quad_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    // First stage captures the asynchronous pins
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage re-registers the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/quad_decoder.sv
// Module: times-four quadrature direction decoder.
// Compares the synchronized phase pair with the pair held from the last tick.
// Assumes a and b are already synchronous; an unchanged pair or a double change
// yields no step, and the reference always moves to the newest pair.
module quad_decoder
    import quad_index_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  a,
    input  logic  b,
    output step_t step
);
    logic       a_ref, b_ref;
    logic [1:0] delta;

    // Hold the phase pair seen on the previous enabled tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_ref <= 1'b0;
            b_ref <= 1'b0;
        end else if (tick) begin
            a_ref <= a;
            b_ref <= b;
        end
    end

    // Distance travelled around the four-state cycle picks the direction
    always_comb begin
        delta = phase_pos(a, b) - phase_pos(a_ref, b_ref);
        step  = STEP_NONE;
        if (tick) begin
            if (delta == 2'd1)      step = STEP_UP;
            else if (delta == 2'd3) step = STEP_DOWN;
        end
    end
endmodule

// File: rtl/quad_index.sv
// Module: index edge qualifier and arming logic.
// An active edge seen on one tick is held pending; the clear is issued on the
// next tick only if the index is still active and the clear is armed and enabled.
// Assumes z is synchronous and tick marks count-source timing.
module quad_index (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic z,
    input  logic rising,
    input  logic enable,
    input  logic wr_en,
    input  logic wr_zero,
    output logic clear
);
    logic active;
    logic act_q;
    logic pending;
    logic armed;

    assign active = rising ? z : ~z;
    assign clear  = tick & pending & active & armed & enable;

    // Remember whether the last write left the counter at zero
    always_ff @(posedge clk) begin
        if (!rst_n)     armed <= 1'b0;
        else if (wr_en) armed <= wr_zero;
    end

    // Sample the active level and track a recognised edge for one tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            pending <= 1'b0;
        end else if (tick) begin
            act_q   <= active;
            pending <= !pending && active && !act_q && armed && enable;
        end
    end
endmodule

// File: rtl/quad_counter.sv
// Module: free-running up/down count register with wrap interrupt.
// Priority: load, then clear, then step. A wrap on a clearing tick queues a
// second interrupt cycle. Assumes step is only non-idle on tick cycles.
module quad_counter
    import quad_index_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  step_t            step,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] count,
    output logic             wrap_irq
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic wrap_now;
    logic dbl_q;

    // A step leaving the range in either direction is a wrap
    always_comb begin
        wrap_now = tick && !wr_en &&
                   ((step == STEP_UP   && count == CNT_MAX) ||
                    (step == STEP_DOWN && count == '0));
    end

    // Update the position register
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (wr_en)             count <= wr_data;
        else if (tick) begin
            if (clear)                  count <= '0;
            else if (step == STEP_UP)   count <= count + 1'b1;
            else if (step == STEP_DOWN) count <= count - 1'b1;
        end
    end

    // Issue the interrupt, doubled when a wrap meets an index clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_irq <= 1'b0;
            dbl_q    <= 1'b0;
        end else begin
            wrap_irq <= wrap_now | dbl_q;
            dbl_q    <= wrap_now & clear;
        end
    end
endmodule

// File: rtl/quad_index_counter.sv
// Module: quadrature position counter with index clear (top level).
// Synchronizes the encoder pins, decodes direction, qualifies the index and
// maintains the count. Assumes cnt_en is a single-cycle-per-tick enable.
module quad_index_counter
    import quad_index_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             idx_in,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             idx_enable,
    input  logic             idx_rising,
    output logic [WIDTH-1:0] count,
    output logic             wrap_irq
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] pins_sync;
    step_t            step;
    logic             idx_clear;

    quad_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ph_a, ph_b, idx_in}),
        .dout  (pins_sync)
    );

    quad_decoder u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cnt_en),
        .a     (pins_sync[2]),
        .b     (pins_sync[1]),
        .step  (step)
    );

    quad_index u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_en),
        .z       (pins_sync[0]),
        .rising  (idx_rising),
        .enable  (idx_enable),
        .wr_en   (wr_en),
        .wr_zero (wr_data == '0),
        .clear   (idx_clear)
    );

    quad_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_en),
        .step     (step),
        .clear    (idx_clear),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .count    (count),
        .wrap_irq (wrap_irq)
    );
endmodule

// File: rtl/quad_index_counter_chk.sv
// Module: property checker for the quadrature position counter, bound to the top.
// Assumes it sees the top-level ports and the internal index clear strobe.
module quad_index_counter_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             idx_clear,
    input logic [WIDTH-1:0] count,
    input logic             wrap_irq
);
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count == $past(wr_data));                                   // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_en) |=> $stable(count));                              // R5
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !wr_en) |=> (count == $past(count) ||
                                count == $past(count) + WIDTH'(1) ||
                                count == $past(count) - WIDTH'(1) ||
                                count == '0));                                // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_clear && !wr_en) |=> count == '0);                               // R10
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_irq) |-> $past(cnt_en));                                   // R6
    AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != '0) |=> !idx_clear);                             // R8
endmodule

bind quad_index_counter quad_index_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .idx_clear (idx_clear),
    .count     (count),
    .wrap_irq  (wrap_irq)
);

// File: tb/quad_index_counter_test.sv
// Bench: directed corner cases plus seeded random phase traffic, checked
// against a model kept in bench functions.
module quad_index_counter_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b1;
    logic         ph_a = 1'b0, ph_b = 1'b0, idx_in = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         idx_enable = 1'b0, idx_rising = 1'b1;
    logic [W-1:0] count;
    logic         wrap_irq;

    int     n_chk = 0, n_fail = 0;
    bit     done = 1'b0;
    logic [W-1:0] exp_cnt = '0;
    logic [1:0]   cur_ab = 2'b00;

    quad_index_counter #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ph_a(ph_a), .ph_b(ph_b),
        .idx_in(idx_in), .wr_en(wr_en), .wr_data(wr_data),
        .idx_enable(idx_enable), .idx_rising(idx_rising),
        .count(count), .wrap_irq(wrap_irq)
    );

    always #10 clk = ~clk;

    // Forward cycle position, per the requirement encoding
    function automatic int pos_of(input logic [1:0] ab);
        case (ab)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [1:0] ab_at(input int p);
        case (p % 4)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Drive a phase pair, check count and irq on the third edge, irq gone next
    task automatic move(input logic [1:0] nab, input string req);
        int  d;
        bit  wrp;
        d = (pos_of(nab) - pos_of(cur_ab) + 4) % 4;
        wrp = (d == 1 && exp_cnt == '1) || (d == 3 && exp_cnt == '0);
        if (d == 1)      exp_cnt = exp_cnt + 1'b1;
        else if (d == 3) exp_cnt = exp_cnt - 1'b1;
        {ph_a, ph_b} = nab;
        cur_ab = nab;
        edges(3);
        chk(req, count, exp_cnt);
        chk(req, wrap_irq, wrp);
        edges(1);
        chk(req, wrap_irq, 0);
    endtask

    task automatic write(input logic [W-1:0] v, input string req);
        wr_en = 1'b1; wr_data = v;
        edges(1);
        wr_en = 1'b0;
        exp_cnt = v;
        chk(req, count, v);
    endtask

    // Watchdog: a hang counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        edges(3);
        chk("R1 reset count", count, 0);
        chk("R1 reset irq", wrap_irq, 0);
        rst_n = 1'b1;
        edges(2);
        chk("R1 after release", count, 0);
        chk("R1 irq after release", wrap_irq, 0);

        // R2 exact latency: unchanged after two edges, stepped on the third
        {ph_a, ph_b} = 2'b10; cur_ab = 2'b10;
        edges(2);
        chk("R2 not before third edge", count, 0);
        edges(1);
        chk("R2 on third edge", count, 1);
        exp_cnt = 1;
        edges(1);
        move(2'b11, "R2 up");
        move(2'b01, "R2 up");
        move(2'b00, "R2 up");
        move(2'b01, "R3 down");
        move(2'b11, "R3 down");
        move(2'b00, "R4 double change");
        move(2'b10, "R4 reference moved");

        // R5: enable low freezes sampling
        cnt_en = 1'b0;
        {ph_a, ph_b} = 2'b11;
        edges(6);
        chk("R5 no count while disabled", count, 3);
        cnt_en = 1'b1;
        edges(1);
        chk("R5 counted on first enabled tick", count, 4);
        cur_ab = 2'b11; exp_cnt = 4;
        edges(1);

        // R7 load and R6 wrap both ways
        write(16'hFFFF, "R7 load");
        move(2'b01, "R6 overflow wrap");
        move(2'b11, "R6 underflow wrap");

        // R8: enabled but not armed (last write non-zero)
        idx_enable = 1'b1;
        idx_in = 1'b1; edges(6); idx_in = 1'b0; edges(4);
        chk("R8 unarmed index ignored", count, 16'hFFFF);
        idx_enable = 1'b0;
        write(16'h0000, "R8 arming write");
        move(2'b01, "R13 setup");
        idx_in = 1'b1; edges(6); idx_in = 1'b0; edges(4);
        chk("R13 disabled index ignored", count, 1);

        // R10 exact clear timing
        idx_enable = 1'b1;
        idx_in = 1'b1;
        edges(3);
        chk("R10 not cleared on recognising tick", count, 1);
        edges(1);
        chk("R10 cleared on next tick", count, 0);
        exp_cnt = 0;
        idx_in = 1'b0; edges(4);

        // R10 step on clearing tick discarded
        move(2'b00, "R10 setup");
        idx_in = 1'b1;
        edges(1);
        {ph_a, ph_b} = 2'b10; cur_ab = 2'b10;
        edges(3);
        chk("R10 step discarded", count, 0);
        chk("R10 no irq", wrap_irq, 0);
        exp_cnt = 0;
        edges(1);
        chk("R10 no irq later", wrap_irq, 0);
        idx_in = 1'b0; edges(4);

        // R11 one-cycle glitch rejected
        move(2'b11, "R11 setup");
        idx_in = 1'b1; edges(1); idx_in = 1'b0; edges(6);
        chk("R11 glitch rejected", count, 1);

        // R9 falling polarity
        idx_enable = 1'b0;
        idx_in = 1'b1; idx_rising = 1'b0;
        edges(4);
        idx_enable = 1'b1;
        edges(4);
        chk("R9 idle high no clear", count, 1);
        idx_in = 1'b0;
        edges(3);
        chk("R9 falling not yet", count, 1);
        edges(1);
        chk("R9 falling clears", count, 0);
        exp_cnt = 0;
        edges(2);
        move(2'b01, "R9 setup");
        idx_in = 1'b1; edges(6);
        chk("R9 rising ignored when falling selected", count, 1);
        idx_enable = 1'b0; idx_in = 1'b0; edges(4);
        idx_rising = 1'b1; edges(4);

        // R12 wrap coinciding with clear
        move(2'b11, "R12 setup");
        move(2'b10, "R12 setup wrap");
        idx_enable = 1'b1;
        idx_in = 1'b1;
        edges(1);
        {ph_a, ph_b} = 2'b11; cur_ab = 2'b11;
        edges(3);
        chk("R12 count zero", count, 0);
        chk("R12 first pulse", wrap_irq, 1);
        edges(1);
        chk("R12 second pulse", wrap_irq, 1);
        edges(1);
        chk("R12 pulses end", wrap_irq, 0);
        exp_cnt = 0;
        idx_in = 1'b0; idx_enable = 1'b0; edges(4);

        // Random phase traffic with occasional loads
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom % 16;
            if (r == 0)
                move(ab_at(pos_of(cur_ab) + 2), "R4 random double change");
            else if (r == 1)
                write(($urandom % 2) ? 16'hFFFF : W'($urandom), "R7 random load");
            else if (r < 9)
                move(ab_at(pos_of(cur_ab) + 1), "R2 random up");
            else
                move(ab_at(pos_of(cur_ab) + 3), "R3 random down");
        end

        done = 1'b1;
        report();
    end
endmodule